// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the memory side of a two-wire serial bus. It oversamples the clock line (SCL) and the data line (SDA) with the system clock, finds START and STOP conditions, and decodes the control byte that follows each START. It answers only when the fixed device code and the select bits match. A write control byte is followed by a word address and then data bytes. The data bytes collect in a page buffer and are committed to an internal register array at STOP. A read control byte makes the block shift out bytes from its address pointer for as long as the master acknowledges.

The three select bits of the control byte are split between strap pins and upper array-block bits. The split follows the `MEM_KBIT` parameter: 2 gives three pin bits, 4 gives two, 8 gives one and 16 gives none. SDA is open-drain: `sda_oe` high pulls the line low. After a committed write, an internal write cycle of `BUSY_CYCLES` clocks runs, and during it the device does not answer its address.

Top module: `serial_eeprom_target`

## Requirements
- R1: A START (SDA falling while SCL is high) in any state, including a repeated START inside a transfer, restarts control-byte reception. A STOP (SDA rising while SCL is high) releases SDA and returns the block to idle.
- R2: If control-byte bits 7..4 are not 1010, the block does not acknowledge. It drives SDA for no later byte of that transfer and stores nothing.
- R3: Control-byte bits 3..1 carry pin bits in their upper part, compared with `strap_i[2..]`, and block bits in their lower part. With MEM_KBIT=4, bits 3..2 must equal strap_i[2:1] and bit 1 becomes array address bit 8. A mismatch is not acknowledged.
- R4: For a matching control byte, a word address and each write data byte, SDA is held low through the ninth clock. SDA changes only while SCL is low.
- R5: Control-byte bit 0 set to 0 means write and 1 means read. Data is sent and received MSB first. A byte written to an address reads back unchanged.
- R6: During a write, the address advances after each data byte. Its low log2(PAGE_BYTES) bits wrap within the page, so bytes beyond the page end overwrite the start of the same page and never touch the next page.
- R7: While `wp_i` is high at the STOP, nothing is stored and no write cycle starts. Data bytes are still acknowledged.
- R8: After a STOP that ends a write with at least one data byte and `wp_i` low, a matching control byte is not acknowledged for BUSY_CYCLES clocks. After that it is acknowledged again.
- R9: A read returns successive bytes while the master acknowledges. The address advances over the whole array, across page boundaries. A master NACK ends the read with SDA released.
- R10: A read control byte sent without a preceding word address returns the byte after the last one accessed.
- R11: After reset SDA is released and every array byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls SDA low (open-drain) |
| strap_i | input | 3 | Hard-wired device select pins |
| wp_i | input | 1 | Write protect, high blocks stores |

## Verification
The bench builds the block with MEM_KBIT=4, PAGE_BYTES=16 and BUSY_CYCLES=200. This gives one pin-versus-block split in which both a strap mismatch and the block bit can be exercised. A 16-byte page lets a four-byte write starting at offset 14 show the wrap. The short write cycle lets an immediate poll land inside the busy window, and a later poll land after it. A sequential read starting near the page end shows that read addressing is not confined to a page, unlike write addressing.

// File: rtl/sts_pkg.sv
package sts_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CACK,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK
    } phase_e;
endpackage

// File: rtl/sts_bus_sense.sv
module sts_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [2:0] scl_q;
    logic [2:0] sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    assign scl_lvl   = scl_q[1];
    assign sda_lvl   = sda_q[1];
    assign scl_rise  = scl_q[1] & ~scl_q[2];
    assign scl_fall  = ~scl_q[1] & scl_q[2];
    assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/sts_page_buf.sv
module sts_page_buf #(
    parameter int PAGE_BYTES = 16,
    localparam int PG_W = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [PG_W-1:0]         idx,
    input  logic [7:0]              wdata,
    output logic [PAGE_BYTES*8-1:0] data_o,
    output logic [PAGE_BYTES-1:0]   mask_o
);
    logic [7:0] byte_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) byte_q[i] <= '0;
        end else if (clr) begin
            mask_q <= '0;
        end else if (wr) begin
            byte_q[idx] <= wdata;
            mask_q[idx] <= 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
            assign data_o[g*8 +: 8] = byte_q[g];
        end
    endgenerate
    assign mask_o = mask_q;
endmodule

// File: rtl/sts_store.sv
module sts_store #(
    parameter int ADDR_W = 9,
    parameter int PAGE_BYTES = 16,
    localparam int PG_W = $clog2(PAGE_BYTES),
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [ADDR_W-PG_W-1:0]  page_base,
    input  logic [PAGE_BYTES*8-1:0] page_data,
    input  logic [PAGE_BYTES-1:0]   page_mask,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [7:0]              rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (page_mask[i]) mem_q[{page_base, PG_W'(i)}] <= page_data[i*8 +: 8];
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target #(
    parameter int MEM_KBIT = 4,
    parameter int PAGE_BYTES = 16,
    parameter int BUSY_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);
    import sts_pkg::*;

    localparam int BLK_W  = $clog2(MEM_KBIT / 2);
    localparam int ADDR_W = 8 + BLK_W;
    localparam int PG_W   = $clog2(PAGE_BYTES);
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        phase_e            st;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] addr;
        logic              oe;
        logic              macked;
        logic              wr_pend;
        logic [BUSY_W-1:0] busy;
    } core_t;

    core_t q, d;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic buf_wr, buf_clr, commit;
    logic [PAGE_BYTES*8-1:0] buf_data;
    logic [PAGE_BYTES-1:0]   buf_mask;
    logic [7:0] rd_data;
    logic pin_ok;

    sts_bus_sense u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    sts_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr(buf_wr),
        .idx(q.addr[PG_W-1:0]), .wdata(q.sh),
        .data_o(buf_data), .mask_o(buf_mask)
    );

    sts_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .page_base(q.addr[ADDR_W-1:PG_W]), .page_data(buf_data),
        .page_mask(buf_mask), .raddr(q.addr), .rdata(rd_data)
    );

    always_comb begin
        pin_ok = 1'b1;
        for (int i = 0; i < 3; i++)
            if (i >= BLK_W && q.sh[i+1] != strap_i[i]) pin_ok = 1'b0;
    end

    always_comb begin
        d       = q;
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        commit  = 1'b0;
        if (q.busy != '0) d.busy = q.busy - 1'b1;

        if (start_det) begin
            d.st  = ST_CTRL;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
            if (q.wr_pend) begin
                d.wr_pend = 1'b0;
                buf_clr   = 1'b1;
                if (!wp_i) begin
                    commit = 1'b1;
                    d.busy = BUSY_W'(BUSY_CYCLES);
                end
            end
        end else begin
            case (q.st)
                ST_CTRL, ST_ADDR, ST_WDAT: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.st == ST_CTRL) begin
                            if (q.sh[7:4] == DEV_CODE && pin_ok && q.busy == '0) begin
                                d.oe = 1'b1;
                                d.st = ST_CACK;
                                for (int i = 0; i < BLK_W; i++) d.addr[8+i] = q.sh[1+i];
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_ADDR) begin
                            d.oe         = 1'b1;
                            d.addr[7:0]  = q.sh;
                            d.st         = ST_AACK;
                        end else begin
                            d.oe                = 1'b1;
                            buf_wr              = 1'b1;
                            d.wr_pend           = 1'b1;
                            d.addr[PG_W-1:0]    = q.addr[PG_W-1:0] + PG_W'(1);
                            d.st                = ST_WACK;
                        end
                    end
                end
                ST_CACK: if (scl_fall) begin
                    d.cnt = '0;
                    if (q.sh[0]) begin
                        d.sh = rd_data;
                        d.oe = ~rd_data[7];
                        d.st = ST_RDAT;
                    end else begin
                        d.oe = 1'b0;
                        d.st = ST_ADDR;
                    end
                end
                ST_AACK, ST_WACK: if (scl_fall) begin
                    d.oe  = 1'b0;
                    d.cnt = '0;
                    d.st  = ST_WDAT;
                end
                ST_RDAT: if (scl_fall) begin
                    if (q.cnt == 4'd7) begin
                        d.oe   = 1'b0;
                        d.cnt  = '0;
                        d.addr = q.addr + 1'b1;
                        d.st   = ST_RACK;
                    end else begin
                        d.sh  = {q.sh[6:0], 1'b0};
                        d.oe  = ~q.sh[6];
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.macked = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.macked) begin
                            d.sh  = rd_data;
                            d.oe  = ~rd_data[7];
                            d.cnt = '0;
                            d.st  = ST_RDAT;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sh: '0, addr: '0, oe: 1'b0,
                   macked: 1'b0, wr_pend: 1'b0, busy: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
endmodule

// File: rtl/sts_chk.sv
module sts_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         sda_oe,
    input logic         wp_i,
    input logic         scl_lvl,
    input logic         start_det,
    input logic         commit,
    input sts_pkg::phase_e st,
    input logic [7:0]   sh,
    input logic         busy_nz
);
    import sts_pkg::*;

    // R1
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_CTRL && !sda_oe));

    // R2
    code_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CACK) |-> (sh[7:4] == 4'b1010));

    // R4
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

    // R7
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !wp_i);

    // R8
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CACK && $past(st) != ST_CACK) |-> !$past(busy_nz));

    // R9
    rack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RACK) |-> !sda_oe);
endmodule

bind serial_eeprom_target sts_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .wp_i(wp_i),
    .scl_lvl(scl_lvl), .start_det(start_det), .commit(commit),
    .st(q.st), .sh(q.sh), .busy_nz(q.busy != '0)
);

// File: tb/tb_serial_eeprom_target.sv
module tb_serial_eeprom_target;
    localparam int CLK_PERIOD = 10;
    localparam int QP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic drive_low = 1'b0;
    logic [2:0] strap = 3'b101;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;
    int checks = 0;
    int fails = 0;

    assign sda_line = ~(sda_oe | drive_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_eeprom_target #(.MEM_KBIT(4), .PAGE_BYTES(16), .BUSY_CYCLES(200)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .wp_i(wp)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q1();
        repeat (QP) @(negedge clk);
    endtask

    task automatic bus_start();
        drive_low = 1'b0; q1(); scl = 1'b1; q1();
        drive_low = 1'b1; q1(); scl = 1'b0; q1();
    endtask

    task automatic bus_stop();
        drive_low = 1'b1; q1(); scl = 1'b1; q1();
        drive_low = 1'b0; q1();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            drive_low = ~b[i]; q1(); scl = 1'b1; q1(); q1(); scl = 1'b0; q1();
        end
        drive_low = 1'b0; q1(); scl = 1'b1; q1();
        acked = ~sda_line;
        q1(); scl = 1'b0; q1();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        drive_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            q1(); scl = 1'b1; q1(); b[i] = sda_line; q1(); scl = 1'b0; q1();
        end
        drive_low = mack; q1(); scl = 1'b1; q1(); q1(); scl = 1'b0; q1();
        drive_low = 1'b0;
    endtask

    task automatic write_bytes(input logic [7:0] ctrl, input logic [7:0] a,
                               input logic [7:0] d0, input int n, input string req);
        bit ak;
        bus_start();
        send_byte(ctrl, ak); check(ak, req, ak, 1);
        send_byte(a, ak);    check(ak, req, ak, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d0 + 8'(i * 8'h11), ak); check(ak, req, ak, 1);
        end
        bus_stop();
    endtask

    task automatic read_at(input logic [7:0] ctrl, input logic [7:0] a,
                           output logic [7:0] v);
        bit ak;
        bus_start();
        send_byte(ctrl, ak);
        send_byte(a, ak);
        bus_start();
        send_byte(ctrl | 8'h01, ak);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R11", sda_oe, 0);
    endtask

    task automatic t_byte_write();
        bit ak;
        logic [7:0] v;
        write_bytes(8'hA8, 8'h20, 8'h5A, 1, "R4");
        bus_start(); send_byte(8'hA8, ak); bus_stop();
        check(!ak, "R8 poll during write cycle", ak, 0);
        repeat (300) @(negedge clk);
        bus_start(); send_byte(8'hA8, ak); bus_stop();
        check(ak, "R8 poll after write cycle", ak, 1);
        read_at(8'hA8, 8'h20, v);
        check(v == 8'h5A, "R5 R1 random read", v, 8'h5A);
    endtask

    task automatic t_page_wrap();
        logic [7:0] v;
        bit ak;
        write_bytes(8'hA8, 8'h3E, 8'h11, 4, "R6");
        repeat (300) @(negedge clk);
        bus_start();
        send_byte(8'hA8, ak); send_byte(8'h3E, ak);
        bus_start(); send_byte(8'hA9, ak);
        recv_byte(1'b1, v); check(v == 8'h11, "R9 seq byte0", v, 8'h11);
        recv_byte(1'b1, v); check(v == 8'h22, "R9 seq byte1", v, 8'h22);
        recv_byte(1'b1, v); check(v == 8'h00, "R6 R9 next page untouched", v, 0);
        recv_byte(1'b0, v); check(v == 8'h00, "R9 seq byte3", v, 0);
        check(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
        bus_stop();
        read_at(8'hA8, 8'h30, v);
        check(v == 8'h33, "R6 wrapped byte", v, 8'h33);
        bus_start(); send_byte(8'hA9, ak); recv_byte(1'b0, v); bus_stop();
        check(v == 8'h44, "R10 current address read", v, 8'h44);
    endtask

    task automatic t_block_bit();
        logic [7:0] v;
        write_bytes(8'hAA, 8'h30, 8'h77, 1, "R3");
        repeat (300) @(negedge clk);
        read_at(8'hA8, 8'h30, v);
        check(v == 8'h33, "R3 block0 kept", v, 8'h33);
        read_at(8'hAA, 8'h30, v);
        check(v == 8'h77, "R3 block1 data", v, 8'h77);
    endtask

    task automatic t_mismatch();
        bit ak;
        logic [7:0] v;
        bus_start(); send_byte(8'hA4, ak);
        check(!ak, "R3 strap mismatch nack", ak, 0);
        send_byte(8'h30, ak);
        check(!ak, "R3 later byte ignored", ak, 0);
        bus_stop();
        bus_start(); send_byte(8'hB8, ak);
        check(!ak, "R2 code mismatch nack", ak, 0);
        send_byte(8'h30, ak);
        check(!ak, "R2 address ignored", ak, 0);
        send_byte(8'hEE, ak);
        check(!ak, "R2 data ignored", ak, 0);
        bus_stop();
        read_at(8'hA8, 8'h30, v);
        check(v == 8'h33, "R2 no store", v, 8'h33);
    endtask

    task automatic t_protect();
        bit ak;
        logic [7:0] v;
        wp = 1'b1;
        write_bytes(8'hA8, 8'h30, 8'h99, 1, "R7");
        bus_start(); send_byte(8'hA8, ak); bus_stop();
        check(ak, "R7 no write cycle", ak, 1);
        wp = 1'b0;
        read_at(8'hA8, 8'h30, v);
        check(v == 8'h33, "R7 store blocked", v, 8'h33);
    endtask

    initial begin
        fork
            begin
                repeat (5) @(negedge clk);
                rst_n = 1'b1;
                repeat (5) @(negedge clk);
                t_reset();
                t_byte_write();
                t_page_wrap();
                t_block_bit();
                t_mismatch();
                t_protect();
            end
            begin
                repeat (150000) @(negedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule